// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block holds the host-visible registers of a two-channel ATA/ATAPI disk interface on an 8-bit I/O bus. Each channel has two drive slots. A configuration input gives each slot a type: empty, hard disk or packet device. The block decodes the legacy primary and secondary port windows. It keeps the sector count, sector number and cylinder registers separately for each drive. For each channel it keeps the error, drive/head and status registers, the interrupt-disable bit and an interrupt output.

Each channel runs a two-state software-reset machine. In RUN the channel works normally. The transition SRST_ASSERT moves it to HOLD when a device-control write sets the soft-reset bit. The transition SRST_RELEASE moves it back to RUN when a device-control write clears that bit. Both transitions load fixed values into the registers, and the release also reloads a per-drive cylinder signature that depends on the drive type.

A small command decoder runs on writes to the command port. The packet command sent to a packet drive readies that drive for a data transfer. Any other command takes the abort path, which raises an interrupt. The interrupt is a level and stays high until software reads status through the command port. Data-port transfers, DMA and media access are not part of this block.

Top module: `ata_regfile_ctrl`

## Requirements
- R1: Channel 0 answers addresses with (addr & 0xFFF8)==0x01F0 or (addr & 0xFFFE)==0x03F6, and channel 1 answers the same tests against 0x0170 and 0x0376. Reads of any other address, and reads of offset 0, return 0x00. Writes to other addresses change nothing.
- R2: Offsets 2, 3, 4 and 5 are sector count, sector number, cylinder low and cylinder high. Each drive has its own copy of these four registers. Bit 4 of drive/head picks which drive's copy is read or written.
- R3: After reset: error 0x01, drive/head 0x00, status 0x00, interrupt-disable 0, interrupt low. Every drive has sector count 1, sector number 1 and cylinder 0.
- R4: A write to the control port (offset 6 of the control window) with bit 2 set while in RUN (SRST_ASSERT) sets status to 0x90 and error to 0x01 and clears interrupt-disable. Any other control write loads interrupt-disable from bit 1.
- R5: A control write with bit 2 clear while in HOLD (SRST_RELEASE) clears status bit 7, sets status bit 6, zeroes drive/head bits 3:0 and loads interrupt-disable from bit 1. It also resets both drives of the channel to sector count 1, sector number 1 and cylinder 0xEB14 (high byte 0xEB) for a packet drive or 0x0000 for any other type.
- R6: A write to drive/head (offset 6) stores the data ORed with 0xA0. If the newly selected slot is empty, error bit 2 and status bit 0 are also set.
- R7: While the selected slot is empty, a read of drive/head returns 0xA0 and a read of any other task-file register or of the control port returns 0x00.
- R8: A read of the address register port (the control window at odd address, 0x03F7 or 0x0377) always returns 0xFF.
- R9: Writing 0xA0 to the command port (offset 7) while a packet drive is selected sets that drive's sector count to 1, clears status bits 7, 5 and 0, sets status bit 3 and raises no interrupt.
- R10: Any other command write sets status to 0x41 and error to 0x04. It also raises the channel interrupt, unless interrupt-disable is set.
- R11: The interrupt output stays high until status is read at offset 7, and that read clears it. A read of the control port leaves it unchanged.
- R12: A write to offset 1 (features) does not change what a read of offset 1 (error) returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from io_addr |
| slot_cfg | input | 8 | Slot types, 2 bits per slot at [4*ch+2*drv]: 0 empty, 1 disk, 2 packet |
| irq | output | 2 | Interrupt level per channel |

## Verification
Four port rules are checked on every cycle:
- the address register port always reads 0xFF;
- unmapped reads return zero;
- a rising interrupt always follows a command-port write to its own channel;
- a status read at offset 7 drops the interrupt by the next cycle, while a control-port read leaves it unchanged.

Only the bench scenarios can show:
- the reset sequence and the type-dependent cylinder signatures;
- the per-drive register banks;
- the empty-slot read masking;
- the command outcomes.

The bench checks these against a register model fed by random and directed accesses, using two different slot configurations.

// File: rtl/ata_pkg.sv
package ata_pkg;
    localparam logic [1:0] SLOT_NONE   = 2'd0;
    localparam logic [1:0] SLOT_DISK   = 2'd1;
    localparam logic [1:0] SLOT_PACKET = 2'd2;

    localparam logic [7:0] CMD_PACKET   = 8'hA0;
    localparam logic [7:0] DH_FIXED     = 8'hA0;
    localparam logic [7:0] ST_RST_HOLD  = 8'h90;
    localparam logic [7:0] ST_ABORT     = 8'h41;
    localparam logic [7:0] ERR_DIAG_OK  = 8'h01;
    localparam logic [7:0] ERR_ABRT     = 8'h04;
    localparam logic [15:0] SIG_PACKET  = 16'hEB14;

    typedef enum logic {CH_RUN, CH_HOLD} ch_state_t;
endpackage

// File: rtl/ata_port_decode.sv
module ata_port_decode #(
    parameter int AW = 16,
    parameter logic [AW-1:0] TF0 = AW'(16'h01F0),
    parameter logic [AW-1:0] CT0 = AW'(16'h03F6),
    parameter logic [AW-1:0] TF1 = AW'(16'h0170),
    parameter logic [AW-1:0] CT1 = AW'(16'h0376)
) (
    input  logic [AW-1:0] addr,
    output logic [1:0]    hit,
    output logic          is_ctl,
    output logic          is_alt,
    output logic [2:0]    ofs
);
    localparam logic [AW-1:0] TF_MASK = ~AW'(7);
    localparam logic [AW-1:0] CT_MASK = ~AW'(1);

    logic t0, t1, c0, c1;

    always_comb begin
        t0     = (addr & TF_MASK) == TF0;
        t1     = (addr & TF_MASK) == TF1;
        c0     = (addr & CT_MASK) == CT0;
        c1     = (addr & CT_MASK) == CT1;
        hit    = {t1 | c1, t0 | c0};
        is_ctl = (c0 | c1) & ~addr[0];
        is_alt = (c0 | c1) & addr[0];
        ofs    = addr[2:0];
    end
endmodule

// File: rtl/ata_drive_regs.sv
module ata_drive_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_sig,
    input  logic       is_packet,
    input  logic       pkt_sc,
    input  logic       we,
    input  logic [2:0] ofs,
    input  logic [7:0] wdata,
    output logic [7:0] sc,
    output logic [7:0] sn,
    output logic [7:0] cl,
    output logic [7:0] ch
);
    import ata_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc <= 8'h01;
            sn <= 8'h01;
            cl <= 8'h00;
            ch <= 8'h00;
        end else if (clr_sig) begin
            sc       <= 8'h01;
            sn       <= 8'h01;
            {ch, cl} <= is_packet ? SIG_PACKET : 16'h0000;
        end else begin
            if (pkt_sc) sc <= 8'h01;
            if (we) begin
                case (ofs)
                    3'd2:    sc <= wdata;
                    3'd3:    sn <= wdata;
                    3'd4:    cl <= wdata;
                    3'd5:    ch <= wdata;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ata_channel.sv
module ata_channel (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_wr,
    input  logic       acc_rd,
    input  logic       is_ctl,
    input  logic       is_alt,
    input  logic [2:0] ofs,
    input  logic [7:0] wdata,
    input  logic [3:0] slot_type,
    output logic [7:0] rdata,
    output logic       irq
);
    import ata_pkg::*;

    ch_state_t  st_q, st_d;
    logic [7:0] err_q, stat_q, dh_q;
    logic       nien_q;
    logic       sel;
    logic [1:0] sel_type, new_type;
    logic       tf_wr, tf_rd, ctl_wr, srst_set, srst_clr;
    logic       cmd_wr, pkt_ok, abort, dh_wr, drv_wr;
    logic [7:0] d_sc [2];
    logic [7:0] d_sn [2];
    logic [7:0] d_cl [2];
    logic [7:0] d_ch [2];

    always_comb begin
        sel      = dh_q[4];
        sel_type = slot_type[{sel, 1'b0} +: 2];
        new_type = slot_type[{wdata[4], 1'b0} +: 2];
        tf_wr    = acc_wr & ~is_ctl & ~is_alt;
        tf_rd    = acc_rd & ~is_ctl & ~is_alt;
        ctl_wr   = acc_wr & is_ctl;
        srst_set = ctl_wr & (st_q == CH_RUN) & wdata[2];
        srst_clr = ctl_wr & (st_q == CH_HOLD) & ~wdata[2];
        cmd_wr   = tf_wr & (ofs == 3'd7);
        pkt_ok   = cmd_wr & (wdata == CMD_PACKET) & (sel_type == SLOT_PACKET);
        abort    = cmd_wr & ~pkt_ok;
        dh_wr    = tf_wr & (ofs == 3'd6);
        drv_wr   = tf_wr & (ofs >= 3'd2) & (ofs <= 3'd5);
    end

    // next-state logic of the soft-reset machine
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_RUN:  if (srst_set) st_d = CH_HOLD;
            CH_HOLD: if (srst_clr) st_d = CH_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_RUN;
        else        st_q <= st_d;
    end

    // register outputs driven by transitions and accesses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= ERR_DIAG_OK;
            stat_q <= 8'h00;
            dh_q   <= 8'h00;
            nien_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            if (srst_set) begin
                stat_q <= ST_RST_HOLD;
                err_q  <= ERR_DIAG_OK;
                nien_q <= 1'b0;
            end else if (srst_clr) begin
                stat_q    <= {1'b0, 1'b1, stat_q[5:0]};
                dh_q[3:0] <= 4'h0;
                nien_q    <= wdata[1];
            end else if (ctl_wr) begin
                nien_q <= wdata[1];
            end
            if (dh_wr) begin
                dh_q <= wdata | DH_FIXED;
                if (new_type == SLOT_NONE) begin
                    err_q  <= err_q | ERR_ABRT;
                    stat_q <= stat_q | 8'h01;
                end
            end
            if (pkt_ok) stat_q <= (stat_q & 8'h5E) | 8'h08;
            if (tf_rd && ofs == 3'd7) irq <= 1'b0;
            if (abort) begin
                stat_q <= ST_ABORT;
                err_q  <= ERR_ABRT;
                if (!nien_q) irq <= 1'b1;
            end
        end
    end

    for (genvar d = 0; d < 2; d++) begin : g_drv
        ata_drive_regs u_drv (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_sig   (srst_clr),
            .is_packet (slot_type[2*d +: 2] == SLOT_PACKET),
            .pkt_sc    (pkt_ok & (sel == 1'(d))),
            .we        (drv_wr & (sel == 1'(d))),
            .ofs       (ofs),
            .wdata     (wdata),
            .sc        (d_sc[d]),
            .sn        (d_sn[d]),
            .cl        (d_cl[d]),
            .ch        (d_ch[d])
        );
    end

    always_comb begin
        rdata = 8'h00;
        if (is_alt) begin
            rdata = 8'hFF;
        end else if (sel_type == SLOT_NONE) begin
            rdata = (!is_ctl && ofs == 3'd6) ? DH_FIXED : 8'h00;
        end else if (is_ctl) begin
            rdata = stat_q;
        end else begin
            case (ofs)
                3'd1:    rdata = err_q;
                3'd2:    rdata = d_sc[sel];
                3'd3:    rdata = d_sn[sel];
                3'd4:    rdata = d_cl[sel];
                3'd5:    rdata = d_ch[sel];
                3'd6:    rdata = dh_q;
                3'd7:    rdata = stat_q;
                default: rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/ata_regfile_ctrl.sv
module ata_regfile_ctrl #(
    parameter int AW = 16,
    parameter logic [AW-1:0] TF0 = AW'(16'h01F0),
    parameter logic [AW-1:0] CT0 = AW'(16'h03F6),
    parameter logic [AW-1:0] TF1 = AW'(16'h0170),
    parameter logic [AW-1:0] CT1 = AW'(16'h0376)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] io_addr,
    input  logic          io_wr,
    input  logic          io_rd,
    input  logic [7:0]    io_wdata,
    output logic [7:0]    io_rdata,
    input  logic [7:0]    slot_cfg,
    output logic [1:0]    irq
);
    localparam int NCH = 2;

    logic [NCH-1:0] hit;
    logic           is_ctl, is_alt;
    logic [2:0]     ofs;
    logic [7:0]     ch_rdata [NCH];

    ata_port_decode #(.AW(AW), .TF0(TF0), .CT0(CT0), .TF1(TF1), .CT1(CT1)) u_dec (
        .addr   (io_addr),
        .hit    (hit),
        .is_ctl (is_ctl),
        .is_alt (is_alt),
        .ofs    (ofs)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ata_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_wr    (io_wr & hit[c]),
            .acc_rd    (io_rd & hit[c]),
            .is_ctl    (is_ctl),
            .is_alt    (is_alt),
            .ofs       (ofs),
            .wdata     (io_wdata),
            .slot_type (slot_cfg[4*c +: 4]),
            .rdata     (ch_rdata[c]),
            .irq       (irq[c])
        );
    end

    always_comb begin
        if (hit[0])      io_rdata = ch_rdata[0];
        else if (hit[1]) io_rdata = ch_rdata[1];
        else             io_rdata = 8'h00;
    end
endmodule

// File: rtl/ata_regfile_ctrl_chk.sv
module ata_regfile_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_addr,
    input logic        io_wr,
    input logic        io_rd,
    input logic [7:0]  io_rdata,
    input logic [1:0]  irq
);
    logic mapped;
    assign mapped = ((io_addr & 16'hFFF8) == 16'h01F0) || ((io_addr & 16'hFFFE) == 16'h03F6) ||
                    ((io_addr & 16'hFFF8) == 16'h0170) || ((io_addr & 16'hFFFE) == 16'h0376);

    p_alt_reads_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd && (io_addr == 16'h03F7 || io_addr == 16'h0377) |-> io_rdata == 8'hFF);

    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd && !mapped |-> io_rdata == 8'h00);

    p_irq0_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[0]) |-> $past(io_wr && io_addr == 16'h01F7));

    p_irq1_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[1]) |-> $past(io_wr && io_addr == 16'h0177));

    p_irq0_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd && !io_wr && io_addr == 16'h01F7 |=> !irq[0]);

    p_irq1_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd && !io_wr && io_addr == 16'h0177 |=> !irq[1]);

    p_irq0_ctl_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd && !io_wr && io_addr == 16'h03F6 |=> $stable(irq[0]));
endmodule

bind ata_regfile_ctrl ata_regfile_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_rdata (io_rdata),
    .irq      (irq)
);

// File: tb/tb_ata_regfile_ctrl.sv
`timescale 1ns/1ps
module tb_ata_regfile_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [7:0]  slot_cfg = 8'h92;
    logic [1:0]  irq;

    int errs = 0, checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ata_regfile_ctrl dut (.*);

    // model state
    logic [7:0] m_err [2], m_stat [2], m_dh [2];
    logic       m_nien [2], m_hold [2], m_irq [2];
    logic [7:0] m_sc [4], m_sn [4], m_cl [4], m_ch [4];

    function automatic int ch_of(logic [15:0] a);
        if ((a & 16'hFFF8) == 16'h01F0 || (a & 16'hFFFE) == 16'h03F6) return 0;
        if ((a & 16'hFFF8) == 16'h0170 || (a & 16'hFFFE) == 16'h0376) return 1;
        return -1;
    endfunction

    function automatic bit is_ctlw(logic [15:0] a);
        return (a & 16'hFEFE) == 16'h0276 || (a & 16'hFFFE) == 16'h03F6;
    endfunction

    function automatic logic [1:0] styp(int c, int d);
        return slot_cfg[4*c + 2*d +: 2];
    endfunction

    function automatic logic [7:0] exp_read(logic [15:0] a);
        int c, i;
        c = ch_of(a);
        if (c < 0) return 8'h00;
        if (is_ctlw(a) && a[0]) return 8'hFF;
        i = 2*c + int'(m_dh[c][4]);
        if (styp(c, int'(m_dh[c][4])) == 2'd0)
            return (!is_ctlw(a) && a[2:0] == 3'd6) ? 8'hA0 : 8'h00;
        if (is_ctlw(a)) return m_stat[c];
        case (a[2:0])
            3'd1: return m_err[c];
            3'd2: return m_sc[i];
            3'd3: return m_sn[i];
            3'd4: return m_cl[i];
            3'd5: return m_ch[i];
            3'd6: return m_dh[c];
            3'd7: return m_stat[c];
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_reset();
        for (int c = 0; c < 2; c++) begin
            m_err[c] = 8'h01; m_stat[c] = 8'h00; m_dh[c] = 8'h00;
            m_nien[c] = 0; m_hold[c] = 0; m_irq[c] = 0;
        end
        for (int i = 0; i < 4; i++) begin
            m_sc[i] = 8'h01; m_sn[i] = 8'h01; m_cl[i] = 8'h00; m_ch[i] = 8'h00;
        end
    endtask

    task automatic m_write(logic [15:0] a, logic [7:0] d);
        int c, i;
        c = ch_of(a);
        if (c < 0) return;
        i = 2*c + int'(m_dh[c][4]);
        if (is_ctlw(a)) begin
            if (a[0]) return;
            if (!m_hold[c] && d[2]) begin
                m_stat[c] = 8'h90; m_err[c] = 8'h01; m_nien[c] = 0; m_hold[c] = 1;
            end else if (m_hold[c] && !d[2]) begin
                m_stat[c] = (m_stat[c] & 8'h7F) | 8'h40;
                m_dh[c] = m_dh[c] & 8'hF0;
                m_nien[c] = d[1]; m_hold[c] = 0;
                for (int k = 0; k < 2; k++) begin
                    m_sc[2*c+k] = 8'h01; m_sn[2*c+k] = 8'h01;
                    {m_ch[2*c+k], m_cl[2*c+k]} = (styp(c, k) == 2'd2) ? 16'hEB14 : 16'h0000;
                end
            end else m_nien[c] = d[1];
            return;
        end
        case (a[2:0])
            3'd2: m_sc[i] = d;
            3'd3: m_sn[i] = d;
            3'd4: m_cl[i] = d;
            3'd5: m_ch[i] = d;
            3'd6: begin
                m_dh[c] = d | 8'hA0;
                if (styp(c, int'(d[4])) == 2'd0) begin
                    m_err[c] = m_err[c] | 8'h04; m_stat[c] = m_stat[c] | 8'h01;
                end
            end
            3'd7: begin
                if (d == 8'hA0 && styp(c, int'(m_dh[c][4])) == 2'd2) begin
                    m_stat[c] = (m_stat[c] & 8'h5E) | 8'h08; m_sc[i] = 8'h01;
                end else begin
                    m_stat[c] = 8'h41; m_err[c] = 8'h04;
                    if (!m_nien[c]) m_irq[c] = 1;
                end
            end
            default: ;
        endcase
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic chk_irq(string req);
        chk(req, {6'd0, irq}, {6'd0, m_irq[1], m_irq[0]});
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1;
        @(negedge clk);
        io_wr = 0;
        m_write(a, d);
    endtask

    // read, compare against the model, optionally also against a literal
    task automatic rd(string req, logic [15:0] a, int lit = -1);
        logic [7:0] v;
        int c;
        @(negedge clk);
        io_addr = a; io_rd = 1;
        #1 v = io_rdata;
        chk(req, v, exp_read(a));
        if (lit >= 0) chk(req, v, 8'(lit));
        @(negedge clk);
        io_rd = 0;
        c = ch_of(a);
        if (c >= 0 && !is_ctlw(a) && a[2:0] == 3'd7) m_irq[c] = 0;
        chk_irq(req);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_reset();
    endtask

    function automatic logic [15:0] rand_addr();
        int r, c;
        logic [15:0] unm [4] = '{16'h01E8, 16'h03F5, 16'h0178, 16'h0000};
        r = int'($urandom % 24);
        if (r >= 20) return unm[r-20];
        c = r / 10;
        r = r % 10;
        if (r == 8) return c ? 16'h0376 : 16'h03F6;
        if (r == 9) return c ? 16'h0377 : 16'h03F7;
        return (c ? 16'h0170 : 16'h01F0) + 16'(r);
    endfunction

    task automatic random_phase(int n);
        for (int k = 0; k < n; k++) begin
            logic [15:0] a;
            logic [7:0]  d;
            a = rand_addr();
            if ($urandom % 2) rd("RAND", a);
            else begin
                d = 8'($urandom);
                if (is_ctlw(a)) d = d & 8'h06;
                else if (a[2:0] == 3'd7 && ($urandom % 2)) d = 8'hA0;
                wr(a, d);
                chk_irq("RAND");
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_reset();
        do_reset();
        // R3 power-up values (ch0 drive 0 packet)
        rd("R3", 16'h01F1, 8'h01); rd("R3", 16'h01F2, 8'h01); rd("R3", 16'h01F3, 8'h01);
        rd("R3", 16'h01F4, 8'h00); rd("R3", 16'h01F6, 8'h00); rd("R3", 16'h01F7, 8'h00);
        rd("R8", 16'h03F7, 8'hFF); rd("R8", 16'h0377, 8'hFF);
        rd("R1", 16'h01E8, 8'h00); rd("R1", 16'h01F0, 8'h00);
        wr(16'h01F2, 8'h33);
        wr(16'h01F6, 8'h10);
        rd("R7", 16'h01F6, 8'hA0); rd("R7", 16'h01F7, 8'h00); rd("R7", 16'h03F6, 8'h00);
        wr(16'h01F6, 8'h00);
        rd("R6", 16'h01F6, 8'hA0); rd("R6", 16'h01F1, 8'h05); rd("R6", 16'h01F7, 8'h01);
        rd("R2", 16'h01F2, 8'h33);
        wr(16'h0176, 8'h10); wr(16'h0172, 8'h44); wr(16'h0176, 8'h00);
        rd("R2", 16'h0172, 8'h01);
        wr(16'h0176, 8'h10);
        rd("R2", 16'h0172, 8'h44);
        wr(16'h01F1, 8'hFF);
        rd("R12", 16'h01F1, 8'h05);
        wr(16'h01F7, 8'hEC);
        chk("R10", {7'd0, irq[0]}, 8'h01);
        rd("R11", 16'h03F6, 8'h41);
        chk("R11", {7'd0, irq[0]}, 8'h01);
        rd("R10", 16'h01F1, 8'h04);
        rd("R11", 16'h01F7, 8'h41);
        chk("R11", {7'd0, irq[0]}, 8'h00);
        wr(16'h01F2, 8'h77);
        wr(16'h01F7, 8'hA0);
        rd("R9", 16'h01F7, 8'h48); rd("R9", 16'h01F2, 8'h01);
        chk("R9", {7'd0, irq[0]}, 8'h00);
        wr(16'h03F6, 8'h02); wr(16'h01F7, 8'hEC);
        chk("R10", {7'd0, irq[0]}, 8'h00);
        wr(16'h01F6, 8'h0F); wr(16'h01F4, 8'h77);
        wr(16'h03F6, 8'h06);
        rd("R4", 16'h01F7, 8'h90); rd("R4", 16'h01F1, 8'h01);
        wr(16'h01F7, 8'hEC);
        chk("R4", {7'd0, irq[0]}, 8'h01);
        rd("R11", 16'h01F7, 8'h41);
        wr(16'h03F6, 8'h00);
        rd("R5", 16'h01F6, 8'hA0); rd("R5", 16'h01F7, 8'h41);
        rd("R5", 16'h01F4, 8'h14); rd("R5", 16'h01F5, 8'hEB); rd("R5", 16'h01F3, 8'h01);
        wr(16'h0176, 8'h00); wr(16'h0174, 8'h55);
        wr(16'h0376, 8'h04); wr(16'h0376, 8'h00);
        rd("R5", 16'h0174, 8'h00); rd("R5", 16'h0177, 8'h50);
        random_phase(4000);
        slot_cfg = 8'h24;
        do_reset();
        rd("R3", 16'h0171, 8'h01);
        random_phase(4000);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule